// File: doc/BRIEF.md
# Power Domain Switch Controller

This block gates one switchable power domain through two outputs: an isolation enable that clamps the domain's outputs, and a power-switch enable that connects the domain to its supply. A two-bit control-mode input picks the condition that decides whether the domain should be on. Three choices exist. Software can turn the domain on or off with single-cycle command pulses. The domain can follow the low-power mode of one of two CPUs, with a three-bit mask naming the CPU modes in which it is switched off. It can also follow a four-bit system setpoint index, with a sixteen-bit map naming the setpoints in which it is switched off.

Transitions are sequenced so the domain is never exposed while its supply is missing. Power-down raises isolation first and opens the switch one cycle later. Power-up closes the switch, waits a programmable number of ramp cycles, and only then releases isolation. A request that changes while a sequence is running takes effect only after that sequence has finished. Each instance takes its configuration from its own inputs, so several instances can each control a different domain in a different mode.

Top module: `pwr_domain_gate`

## Requirements
- R1: After reset the domain is on: `iso_en`=0, `psw_en`=1, `dom_on`=1, and the stored software request is "on".
- R2: Power-down raises `iso_en` and drops `dom_on` on one clock edge, then opens the switch (`psw_en`=0) on the next edge. `psw_en` is never 0 while `iso_en` is 0.
- R3: Power-up closes the switch (`psw_en`=1) while isolation stays on. `iso_en` falls and `dom_on` rises exactly `ramp_cycles`+1 edges later, so `ramp_cycles`=0 gives a single-edge ramp.
- R4: In mode 0 (`ctl_mode`=0), an `sw_on` pulse stores an "on" request and an `sw_off` pulse stores an "off" request. The stored request drives the domain from the following edge. When both pulses arrive in the same cycle, the stored request is left unchanged.
- R5: In mode 1, the selected CPU's mode is coded 0=run, 1=wait, 2=stop, 3=suspend. The domain is off when that CPU is in wait with `cpu_off_mask` bit 0 set, in stop with bit 1 set, or in suspend with bit 2 set. It is never switched off while that CPU is in run.
- R6: In mode 1, `cpu_sel`=0 follows `cpu0_mode` and `cpu_sel`=1 follows `cpu1_mode`. The other CPU's mode has no effect.
- R7: In mode 2, the domain is off when bit `setpoint` of `sp_off_map` is 1 and on when that bit is 0. A change in the target is acted on at the next edge.
- R8: Mode 3 is reserved. In mode 3 the domain keeps its current state, whatever the other inputs do.
- R9: While a sequence is running (the isolation-to-switch step, or the ramp), target changes are not acted on. The target in force when the sequence ends is then acted on.
- R10: Software pulses are ignored outside mode 0. They neither change the domain nor alter the stored request that mode 0 uses later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_mode | input | 2 | Control mode: 0 software, 1 CPU mode, 2 setpoint, 3 hold |
| sw_on | input | 1 | Software switch-on pulse |
| sw_off | input | 1 | Software switch-off pulse |
| cpu0_mode | input | 2 | Mode of CPU 0 (0 run, 1 wait, 2 stop, 3 suspend) |
| cpu1_mode | input | 2 | Mode of CPU 1 (same coding) |
| cpu_sel | input | 1 | CPU whose mode is followed in mode 1 |
| cpu_off_mask | input | 3 | Off in wait (bit 0), stop (bit 1), suspend (bit 2) |
| setpoint | input | 4 | Current system setpoint index |
| sp_off_map | input | 16 | Setpoints in which the domain is off |
| ramp_cycles | input | RAMP_W | Ramp wait after switch closure |
| iso_en | output | 1 | Isolation enable |
| psw_en | output | 1 | Power switch enable (1 = supply connected) |
| dom_on | output | 1 | Domain powered and released |

## Verification
Some properties are checked by assertions on every cycle. The switch is never open while isolation is low. Isolation always leads the switch opening by at least one cycle. Isolation is only released while the switch has been closed for a cycle or more. The on flag never claims a domain that is isolated or unpowered. Two mode-specific rules are also checked continuously: in setpoint mode, an off-setpoint starts a power-down, and in the reserved mode an on domain stays on. The bench scenarios are needed for everything tied to exact timing or stored state. That covers the ramp length counted against `ramp_cycles` (including zero), the dropping of simultaneous pulses, CPU selection and the mode mask, holding a request that arrives during a ramp, and the stored software request surviving pulses sent in other modes.

// File: rtl/pwr_domain_gate.sv
module pwr_domain_gate #(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_mode,
  input  logic              sw_on,
  input  logic              sw_off,
  input  logic [1:0]        cpu0_mode,
  input  logic [1:0]        cpu1_mode,
  input  logic              cpu_sel,
  input  logic [2:0]        cpu_off_mask,
  input  logic [3:0]        setpoint,
  input  logic [15:0]       sp_off_map,
  input  logic [RAMP_W-1:0] ramp_cycles,
  output logic              iso_en,
  output logic              psw_en,
  output logic              dom_on
);

  typedef enum logic [1:0] {ST_ON, ST_ISO, ST_OFF, ST_RAMP} state_t;

  state_t            state;
  logic              sw_req;
  logic [RAMP_W-1:0] ramp_cnt;
  logic [1:0]        cpu_m;
  logic              cpu_off;
  logic              want_on;

  assign cpu_m = cpu_sel ? cpu1_mode : cpu0_mode;

  always_comb begin
    case (cpu_m)
      2'd1:    cpu_off = cpu_off_mask[0];
      2'd2:    cpu_off = cpu_off_mask[1];
      2'd3:    cpu_off = cpu_off_mask[2];
      default: cpu_off = 1'b0;
    endcase
  end

  always_comb begin
    case (ctl_mode)
      2'd0:    want_on = sw_req;
      2'd1:    want_on = !cpu_off;
      2'd2:    want_on = !sp_off_map[setpoint];
      default: want_on = (state == ST_ON);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sw_req <= 1'b1;
    else if (ctl_mode == 2'd0 && (sw_on ^ sw_off))
      sw_req <= sw_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ON;
      ramp_cnt <= '0;
    end else begin
      case (state)
        ST_ON:   if (!want_on) state <= ST_ISO;
        ST_ISO:  state <= ST_OFF;
        ST_OFF:  if (want_on) begin
                   state    <= ST_RAMP;
                   ramp_cnt <= ramp_cycles;
                 end
        default: if (ramp_cnt == '0) state <= ST_ON;
                 else ramp_cnt <= ramp_cnt - 1'b1;
      endcase
    end
  end

  assign iso_en = (state != ST_ON);
  assign psw_en = (state != ST_OFF);
  assign dom_on = (state == ST_ON);

  assert_open_needs_iso_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_en |-> iso_en);

  assert_iso_leads_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psw_en) |-> $past(iso_en));

  assert_release_after_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (psw_en && $past(psw_en)));

  assert_on_flag_consistent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dom_on |-> (psw_en && !iso_en));

  assert_setpoint_off_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'd2 && dom_on && sp_off_map[setpoint]) |=> iso_en);

  assert_hold_mode_keeps_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'd3 && dom_on) |=> dom_on);

endmodule

// File: tb/pwr_domain_gate_bench.sv
module pwr_domain_gate_bench;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ctl_mode = 2'd0;
  logic          sw_on = 1'b0, sw_off = 1'b0;
  logic [1:0]    cpu0_mode = 2'd0, cpu1_mode = 2'd0;
  logic          cpu_sel = 1'b0;
  logic [2:0]    cpu_off_mask = 3'd0;
  logic [3:0]    setpoint = 4'd0;
  logic [15:0]   sp_off_map = 16'd0;
  logic [RW-1:0] ramp_cycles = 8'd3;
  logic          iso_en, psw_en, dom_on;

  pwr_domain_gate #(.RAMP_W(RW)) u_pwr_domain_gate (
    .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .sw_on(sw_on), .sw_off(sw_off),
    .cpu0_mode(cpu0_mode), .cpu1_mode(cpu1_mode), .cpu_sel(cpu_sel),
    .cpu_off_mask(cpu_off_mask), .setpoint(setpoint), .sp_off_map(sp_off_map),
    .ramp_cycles(ramp_cycles), .iso_en(iso_en), .psw_en(psw_en), .dom_on(dom_on));

  always #10 clk = ~clk;

  typedef struct { int cyc; logic [2:0] v; int req; } item_t;
  item_t exp_q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int off, logic iso, logic psw, logic on, int req);
    item_t it;
    it.cyc = cyc + off; it.v = {iso, psw, on}; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic on_p, logic off_p);
    sw_on = on_p; sw_off = off_p;
    step(1);
    sw_on = 1'b0; sw_off = 1'b0;
  endtask

  // monitor: compares every queued expectation that falls due this cycle
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].cyc <= cyc) begin
        n_chk++;
        if (exp_q[i].cyc < cyc || {iso_en, psw_en, dom_on} !== exp_q[i].v) begin
          n_fail++;
          $display("FAIL R%0d cycle %0d: iso/psw/on actual %b expected %b",
                   exp_q[i].req, exp_q[i].cyc, {iso_en, psw_en, dom_on}, exp_q[i].v);
        end
        exp_q.delete(i);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(1, 0, 1, 1, 1); expect_at(3, 0, 1, 1, 1);
    step(4);
    // R4 and R2: software off pulse, isolation then switch
    expect_at(1, 0, 1, 1, 4); expect_at(2, 1, 1, 0, 2); expect_at(3, 1, 0, 0, 2);
    expect_at(6, 1, 0, 0, 4);
    pulse(0, 1); step(7);
    // R3: software on pulse, ramp of 3
    expect_at(1, 1, 0, 0, 3); expect_at(2, 1, 1, 0, 3); expect_at(5, 1, 1, 0, 3);
    expect_at(6, 0, 1, 1, 3);
    pulse(1, 0); step(7);
    // R4: both pulses together keep state and stored request
    expect_at(2, 0, 1, 1, 4); expect_at(4, 0, 1, 1, 4);
    pulse(1, 1); step(5);
    // R3: zero ramp
    ramp_cycles = 8'd0;
    pulse(0, 1); step(4);
    expect_at(2, 1, 1, 0, 3); expect_at(3, 0, 1, 1, 3);
    pulse(1, 0); step(4);
    // R5, R6: CPU mode control
    ramp_cycles = 8'd2;
    ctl_mode = 2'd1; cpu0_mode = 2'd0; cpu1_mode = 2'd2; cpu_sel = 1'b0; cpu_off_mask = 3'b111;
    expect_at(1, 0, 1, 1, 6); expect_at(4, 0, 1, 1, 5);
    step(5);
    cpu_sel = 1'b1;
    expect_at(1, 1, 1, 0, 6); expect_at(2, 1, 0, 0, 6);
    step(4);
    cpu1_mode = 2'd1; cpu_off_mask = 3'b110;
    expect_at(1, 1, 1, 0, 5); expect_at(3, 1, 1, 0, 5); expect_at(4, 0, 1, 1, 5);
    step(6);
    cpu1_mode = 2'd3; cpu_off_mask = 3'b100;
    expect_at(1, 1, 1, 0, 5); expect_at(2, 1, 0, 0, 5);
    step(4);
    cpu1_mode = 2'd0; cpu_off_mask = 3'b111;
    expect_at(4, 0, 1, 1, 5);
    step(6);
    // R7: setpoint control
    sp_off_map = 16'h0020; setpoint = 4'd4; ctl_mode = 2'd2;
    expect_at(2, 0, 1, 1, 7);
    step(4);
    setpoint = 4'd5;
    expect_at(1, 1, 1, 0, 7); expect_at(2, 1, 0, 0, 7);
    step(4);
    setpoint = 4'd15;
    expect_at(1, 1, 1, 0, 7); expect_at(4, 0, 1, 1, 7);
    step(6);
    // R9: off request during ramp is held until ramp ends
    ramp_cycles = 8'd4; setpoint = 4'd5;
    step(4);
    setpoint = 4'd4;
    expect_at(1, 1, 1, 0, 9); expect_at(3, 1, 1, 0, 9); expect_at(5, 1, 1, 0, 9);
    expect_at(6, 0, 1, 1, 9); expect_at(7, 1, 1, 0, 9); expect_at(8, 1, 0, 0, 9);
    step(2);
    setpoint = 4'd5;
    step(10);
    // R10: pulses ignored outside mode 0
    setpoint = 4'd4;
    step(8);
    expect_at(1, 0, 1, 1, 10); expect_at(4, 0, 1, 1, 10);
    pulse(0, 1); step(5);
    ctl_mode = 2'd0;
    expect_at(2, 0, 1, 1, 10); expect_at(4, 0, 1, 1, 10);
    step(5);
    // R8: reserved mode holds on and off
    ctl_mode = 2'd3; setpoint = 4'd5; cpu_sel = 1'b0; cpu0_mode = 2'd3;
    expect_at(1, 0, 1, 1, 8); expect_at(4, 0, 1, 1, 8);
    pulse(0, 1); step(4);
    ctl_mode = 2'd2;
    step(4);
    ctl_mode = 2'd3; setpoint = 4'd4;
    expect_at(1, 1, 0, 0, 8); expect_at(4, 1, 0, 0, 8);
    pulse(1, 0); step(5);
    while (exp_q.size() != 0) step(1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule